// File: doc/BRIEF.md
# Two-Wire Timekeeper Register Slave

This block is the bus-facing front end of a small timekeeping device. It watches an open-drain two-wire bus, with SCL driven by the master and SDA shared, through the chip's system clock. It finds start and stop conditions and answers one fixed 7-bit device address. It gives byte-wide read and write access to a 64-byte register space through a pointer that steps forward on its own. The space is laid out as seconds, minutes, century/hours, day, date, month, years and control, followed by general RAM. Successive accesses walk the space in that order and wrap back to the seconds byte.

A power-good input from the supply monitor gates the whole bus side. When power leaves tolerance, the block drops any transfer in progress and releases SDA. It also returns the pointer to byte 0 and ignores the bus until power comes back. A write starts with the device address and then one byte that sets the pointer; any further bytes are stored. A read returns bytes from the current pointer. A repeated start after the pointer byte gives a read from a chosen location.

Top module: `tkbus_slave`

## Requirements
- R1: After reset the pointer is 0, SDA is released (`sda_oe` low), and every register byte reads back as 0x00.
- R2: Only the address byte 0xD0 (7-bit address 0x68 with write) or 0xD1 (with read) is acknowledged. After any other address byte the slave does not pull SDA low and stays silent until the next start.
- R3: A start is SDA falling while SCL is high, and it is accepted in any state. A stop is SDA rising while SCL is high. A stop releases SDA, returns the slave to idle and leaves the pointer unchanged.
- R4: In a write, the first byte after the address byte loads the pointer with its value modulo 64 and is acknowledged.
- R5: Each further written byte is stored at the pointer and acknowledged by pulling SDA low during the ninth SCL clock. The pointer then increments.
- R6: In a read, the slave sends the byte at the pointer MSB first. It changes SDA only after SCL falls, and the pointer increments after each byte. A master ACK (SDA low on the ninth clock) makes the slave send the next byte.
- R7: After a master NACK the slave leaves SDA released until the next start.
- R8: The pointer wraps from 63 to 0 in both reads and writes.
- R9: While `supply_ok` is low, the transfer in progress is abandoned. From the next cycle on, the pointer is 0 and SDA is released.
- R10: While `supply_ok` is low the bus is ignored: no address is acknowledged and no byte is stored. Bus activity is recognised again once `supply_ok` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | High while the supply is within tolerance |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | High to pull SDA low (open-drain drive) |

## Verification
The bench builds the block with its default parameters: 64 bytes, device address 0x68 and two synchroniser stages. At these values the pointer wrap is reached in a handful of bytes by loading the pointer to 62. The bench drives SCL with eight-cycle half periods, which leaves room for the synchroniser latency before each sampling point. That spacing lets the reference model flag any SDA drive outside an acknowledge or read slot. It also lets the bench place a supply dip in the middle of a data byte and confirm that the following current-address read starts again at byte 0.

// File: rtl/tkbus_pkg.sv
package tkbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WRITE,
    ST_WRITE_ACK,
    ST_SEND,
    ST_HOST_ACK
  } tkbus_state_e;

  localparam int BYTE_BITS = 8;

  // Append one received bit below the bits already gathered (MSB first on the wire).
  function automatic logic [BYTE_BITS-1:0] shift_in(input logic [BYTE_BITS-1:0] cur,
                                                     input logic bit_i);
    return {cur[BYTE_BITS-2:0], bit_i};
  endfunction

  // Drive level for open-drain output: pull low when the data bit is zero.
  function automatic logic pull_for(input logic data_bit);
    return ~data_bit;
  endfunction

endpackage

// File: rtl/tkbus_line_sync.sv
module tkbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic ev_scl_rise,
  output logic ev_scl_fall,
  output logic ev_start,
  output logic ev_stop
);

  // Index STAGES-1 is the synchronised level, index STAGES the previous one.
  logic [STAGES:0] scl_pipe;
  logic [STAGES:0] sda_pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_was, sda_now, sda_was;
  assign scl_now = scl_pipe[STAGES-1];
  assign scl_was = scl_pipe[STAGES];
  assign sda_now = sda_pipe[STAGES-1];
  assign sda_was = sda_pipe[STAGES];

  assign sda_lvl     = sda_now;
  assign ev_scl_rise = scl_now & ~scl_was;
  assign ev_scl_fall = ~scl_now & scl_was;
  assign ev_start    = scl_now & scl_was & sda_was & ~sda_now;
  assign ev_stop     = scl_now & scl_was & ~sda_was & sda_now;

endmodule

// File: rtl/tkbus_regfile.sv
module tkbus_regfile #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [7:0]       rdata
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/tkbus_protocol.sv
module tkbus_protocol
  import tkbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             sda_lvl,
  input  logic             ev_scl_rise,
  input  logic             ev_scl_fall,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_en,
  output logic [7:0]       wr_data
);

  localparam logic [3:0] FULL_CNT = 4'(BYTE_BITS);
  localparam logic [3:0] LAST_TX  = 4'(BYTE_BITS - 1);

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_fold(input logic [7:0] b);
    return PTR_W'(int'(b) % DEPTH);
  endfunction

  tkbus_state_e state;
  logic [3:0]   cnt;
  logic [7:0]   rx_sh;
  logic [7:0]   tx_sh;
  logic         is_read;
  logic         ptr_loaded;
  logic         host_nack;

  logic byte_in_done;
  assign byte_in_done = ev_scl_fall && (cnt == FULL_CNT);

  assign wr_en   = supply_ok && !ev_start && !ev_stop && (state == ST_WRITE)
                   && byte_in_done && ptr_loaded;
  assign wr_data = rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      is_read    <= 1'b0;
      ptr_loaded <= 1'b0;
      host_nack  <= 1'b0;
      sda_oe     <= 1'b0;
      ptr        <= '0;
    end else if (!supply_ok) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
      ptr    <= '0;
    end else if (ev_start) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (ev_stop) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (ev_scl_rise && cnt < FULL_CNT) begin
            rx_sh <= shift_in(rx_sh, sda_lvl);
            cnt   <= cnt + 1'b1;
          end else if (byte_in_done) begin
            if (rx_sh[7:1] == DEV_ADDR) begin
              state      <= ST_ADDR_ACK;
              sda_oe     <= 1'b1;
              is_read    <= rx_sh[0];
              ptr_loaded <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev_scl_fall) begin
            cnt <= '0;
            if (is_read) begin
              state  <= ST_SEND;
              tx_sh  <= rd_data;
              sda_oe <= pull_for(rd_data[7]);
            end else begin
              state  <= ST_WRITE;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_WRITE: begin
          if (ev_scl_rise && cnt < FULL_CNT) begin
            rx_sh <= shift_in(rx_sh, sda_lvl);
            cnt   <= cnt + 1'b1;
          end else if (byte_in_done) begin
            state  <= ST_WRITE_ACK;
            sda_oe <= 1'b1;
            if (!ptr_loaded) begin
              ptr        <= ptr_fold(rx_sh);
              ptr_loaded <= 1'b1;
            end else begin
              ptr <= ptr_step(ptr);
            end
          end
        end
        ST_WRITE_ACK: begin
          if (ev_scl_fall) begin
            state  <= ST_WRITE;
            sda_oe <= 1'b0;
            cnt    <= '0;
          end
        end
        ST_SEND: begin
          if (ev_scl_fall) begin
            if (cnt == LAST_TX) begin
              state  <= ST_HOST_ACK;
              sda_oe <= 1'b0;
              cnt    <= '0;
              ptr    <= ptr_step(ptr);
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= pull_for(tx_sh[6]);
              cnt    <= cnt + 1'b1;
            end
          end
        end
        ST_HOST_ACK: begin
          if (ev_scl_rise) begin
            host_nack <= sda_lvl;
          end else if (ev_scl_fall) begin
            if (!host_nack) begin
              state  <= ST_SEND;
              tx_sh  <= rd_data;
              sda_oe <= pull_for(rd_data[7]);
              cnt    <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/tkbus_slave.sv
module tkbus_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         DEPTH       = 64,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic             sda_lvl;
  logic             ev_scl_rise;
  logic             ev_scl_fall;
  logic             ev_start;
  logic             ev_stop;
  logic [PTR_W-1:0] cur_ptr;
  logic             wr_en;
  logic [7:0]       wr_data;
  logic [7:0]       rd_data;

  tkbus_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_lvl    (sda_lvl),
    .ev_scl_rise(ev_scl_rise),
    .ev_scl_fall(ev_scl_fall),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop)
  );

  tkbus_protocol #(
    .DEV_ADDR(DEV_ADDR),
    .DEPTH   (DEPTH)
  ) u_proto (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .sda_lvl    (sda_lvl),
    .ev_scl_rise(ev_scl_rise),
    .ev_scl_fall(ev_scl_fall),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .rd_data    (rd_data),
    .sda_oe     (sda_oe),
    .ptr        (cur_ptr),
    .wr_en      (wr_en),
    .wr_data    (wr_data)
  );

  tkbus_regfile #(
    .DEPTH(DEPTH)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .waddr(cur_ptr),
    .wdata(wr_data),
    .raddr(cur_ptr),
    .rdata(rd_data)
  );

endmodule

// File: rtl/tkbus_checker.sv
module tkbus_checker #(
  parameter int  DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok,
  input logic             sda_oe,
  input logic             ev_scl_fall,
  input logic             ev_start,
  input logic             ev_stop,
  input logic [PTR_W-1:0] ptr,
  input logic             wr_en
);

  // R9: a supply dip clears the pointer and frees SDA one cycle later.
  assert_pfail_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (ptr == '0) && !sda_oe);

  // R10: nothing is stored in the cycle after the supply was out of tolerance.
  assert_no_store_pfail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !wr_en);

  // R6: the drive only moves after an SCL fall, a bus condition or a supply dip.
  assert_drive_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |->
      $past(ev_scl_fall || ev_start || ev_stop || !supply_ok));

  // R3: a stop releases SDA and keeps the pointer.
  assert_stop_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && supply_ok) |=> !sda_oe);

  assert_stop_keeps_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && supply_ok) |=> (ptr == $past(ptr)));

  // R8: a store at the top byte leaves the pointer at zero.
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == PTR_W'(DEPTH - 1)) |=> (ptr == '0));

endmodule

bind tkbus_slave tkbus_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_ok  (supply_ok),
  .sda_oe     (sda_oe),
  .ev_scl_fall(ev_scl_fall),
  .ev_start   (ev_start),
  .ev_stop    (ev_stop),
  .ptr        (cur_ptr),
  .wr_en      (wr_en)
);

// File: tb/tkbus_slave_bench.sv
module tkbus_slave_bench;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic may_drive = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  tkbus_slave u_tkbus_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe)
  );

  // Behavioural reference model of the register space and pointer.
  int mem_m [64];
  int ptr_m = 0;
  int n_checks = 0;
  int n_errors = 0;
  int stray = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison: the slave may only pull SDA inside slots the model allows (R7).
  always @(negedge clk) begin
    if (rst_n && sda_oe && !may_drive) stray++;
  end

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    sda_m = 1'b0; half();
    scl_m = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half();
    scl_m = 1'b1; half();
    sda_m = 1'b1; half();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit keep, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half();
      scl_m = 1'b1; half();
      scl_m = 1'b0;
    end
    sda_m = 1'b1;
    may_drive = 1'b1;
    half();
    scl_m = 1'b1; half();
    acked = !sda_line;
    scl_m = 1'b0; half();
    may_drive = keep;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    may_drive = 1'b1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half();
      scl_m = 1'b1; half();
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    half();
    sda_m = give_ack ? 1'b0 : 1'b1;
    half();
    scl_m = 1'b1; half();
    scl_m = 1'b0;
    sda_m = 1'b1;
    half();
    if (!give_ack) may_drive = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] p, input int n, input logic [7:0] d0,
                          input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3,
                          input bit expect_ack);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD0, 1'b0, a);
    check(a == expect_ack, "R2 write address ack", a, expect_ack);
    send_byte(p, 1'b0, a);
    check(a == expect_ack, "R4 pointer byte ack", a, expect_ack);
    if (expect_ack) ptr_m = p % 64;
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : (i == 2) ? d2 : d3;
      send_byte(d, 1'b0, a);
      check(a == expect_ack, "R5 data byte ack", a, expect_ack);
      if (expect_ack) begin
        mem_m[ptr_m] = d;
        ptr_m = (ptr_m + 1) % 64;
      end
    end
    bus_stop();
  endtask

  task automatic cur_read(input int n, input string req);
    bit a;
    logic [7:0] got;
    bus_start();
    send_byte(8'hD1, 1'b1, a);
    check(a, "R2 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, got);
      check(got == mem_m[ptr_m][7:0], req, got, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) % 64;
    end
    bus_stop();
  endtask

  task automatic ptr_read(input logic [7:0] p, input int n, input string req);
    bit a;
    logic [7:0] got;
    bus_start();
    send_byte(8'hD0, 1'b0, a);
    send_byte(p, 1'b0, a);
    ptr_m = p % 64;
    bus_start();
    send_byte(8'hD1, 1'b1, a);
    check(a, "R3 repeated start read ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, got);
      check(got == mem_m[ptr_m][7:0], req, got, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) % 64;
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    bit a;
    for (int i = 0; i < 64; i++) mem_m[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: released SDA after reset, pointer 0, cleared contents
    check(sda_oe == 1'b0, "R1 sda released after reset", sda_oe, 0);
    cur_read(2, "R1 reset contents from pointer 0");

    // R2: foreign address gets no ack and no drive
    bus_start();
    send_byte(8'hA0, 1'b0, a);
    check(!a, "R2 foreign address ignored", a, 0);
    bus_stop();

    // R4 R5 R6: write then readback
    do_write(8'd5, 3, 8'hA5, 8'h3C, 8'h81, 8'h00, 1'b1);
    ptr_read(8'd5, 3, "R6 readback after write");

    // R4: pointer byte above 63 folds modulo 64 (0x47 -> 7)
    do_write(8'h47, 1, 8'h5E, 8'h00, 8'h00, 8'h00, 1'b1);
    ptr_read(8'd7, 1, "R4 pointer folded modulo 64");

    // R8: wrap on write and on read
    do_write(8'd62, 4, 8'h11, 8'h22, 8'h33, 8'h44, 1'b1);
    ptr_read(8'd62, 4, "R8 wrap readback");

    // R3: stop keeps pointer; current read continues at 2
    cur_read(1, "R3 pointer kept across stop");
    // R7: after the NACK above the pointer moved by one and the slave stayed quiet
    cur_read(1, "R7 next byte after NACK");

    // R9: supply dip in the middle of a data byte
    bus_start();
    send_byte(8'hD0, 1'b0, a);
    send_byte(8'd10, 1'b0, a);
    for (int i = 7; i >= 4; i--) begin
      sda_m = 1'b0; half();
      scl_m = 1'b1; half();
      scl_m = 1'b0;
    end
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    check(sda_oe == 1'b0, "R9 sda released on supply dip", sda_oe, 0);
    // R10: address while supply is low is not acknowledged
    bus_start();
    send_byte(8'hD0, 1'b0, a);
    check(!a, "R10 address ignored during dip", a, 0);
    bus_stop();
    supply_ok = 1'b1;
    ptr_m = 0;
    repeat (4) @(negedge clk);
    cur_read(1, "R9 pointer reset by supply dip");

    // R10: whole write attempted during dip stores nothing
    supply_ok = 1'b0;
    do_write(8'd0, 2, 8'h77, 8'h66, 8'h00, 8'h00, 1'b0);
    supply_ok = 1'b1;
    repeat (4) @(negedge clk);
    ptr_read(8'd0, 2, "R10 contents unchanged after dip write");

    check(stray == 0, "R7 no drive outside allowed slots", stray, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule